// File: doc/BRIEF.md
# Two-Wire Slave Command-Pointer Front End

This block sits behind the open-drain SCL and SDA pads of a small port-expander style register bank and turns bus traffic into single-cycle register strobes. It runs from a fast system clock and oversamples both bus lines. Each line first passes through a two-flop synchronizer, then through a filter that accepts a new level only once it has held for `FILT_LEN` clocks. Filtered edges then mark START, STOP and the rising and falling SCL edges that clock the byte engine.

A master writes by sending the slave address with R/W low, then a command byte that loads the register pointer, then any number of data bytes. A master reads by setting the pointer the same way, issuing a repeated START and sending the address with R/W high. The slave then returns register bytes until the master declines one. After every data byte the pointer's lowest bit flips, so the two registers of a pair move back to back. The register port is a plain strobe interface with no back-pressure. The bank must accept `reg_wdata` in the cycle `reg_wr` is high. It must present `reg_rdata` for `reg_idx` combinationally in the cycle `reg_rd` is high.

Top module: `i2cs_cmd_slave`

## Requirements
- R1: The slave responds only to an address byte whose upper seven bits equal `{ADDR_HI, addr_sel[1], addr_sel[0]}` (default ADDR_HI = 5'b11101). Bit 0 of the address byte selects write (0) or read (1). A matching address is acknowledged by holding SDA low for the ninth clock. A non-matching address gets no acknowledge, and no strobe follows it.
- R2: The first byte after a matching write address is acknowledged and is stored as the register pointer; only its low `PTR_W` bits are kept.
- R3: Each later byte of a write is acknowledged and produces a one-clock `reg_wr` pulse. The pulse carries the byte, taken MSB first, on `reg_wdata` and the current pointer on `reg_idx`.
- R4: After each data byte, written or read, the pointer becomes its previous value XOR 1.
- R5: After a repeated START with a matching read address, `reg_rd` pulses for one clock at the SCL fall that ends the acknowledge. The slave captures `reg_rdata` in that cycle and shifts it out MSB first.
- R6: A master acknowledge (SDA low on the ninth clock) makes the slave load and send the next byte. A master NACK makes the slave release SDA and ignore the bus until the next START, with no further `reg_rd`.
- R7: A START or STOP seen in the middle of a byte drops that byte. A START always restarts address reception, so a complete transaction that follows is handled normally.
- R8: SCL or SDA pulses shorter than `FILT_LEN` system clocks have no effect on the transferred data.
- R9: While `rst_n` is low, SDA is released and no strobe is issued. Afterwards the slave is idle and ignores bytes until a START.
- R10: `sda_oe` changes only while SCL is low, so the slave never creates a START or STOP.
- R11: `reg_wr` and `reg_rd` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 2 | Pin-strapped low two bits of the slave address |
| scl_i | input | 1 | Bus clock level as seen at the pad |
| sda_i | input | 1 | Bus data level as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| reg_idx | output | PTR_W | Register pointer, valid with either strobe |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Data written by `reg_wr` |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 8 | Register contents for `reg_idx`, combinational |

## Verification
A vector table covers all four strap settings, each with a write of a register pair followed by a combined read of the same pair. Odd and even command values show that the pointer flips its low bit rather than incrementing. Command values above the register count show that upper pointer bits are dropped. Two vectors with a wrong address show that a foreign address gets neither acknowledge nor strobe. Directed sequences then break a byte with STOP and with START, inject short pulses on each line, decline a read byte, read three bytes in a row to show the wrap within a pair, and reset mid-transaction. Each directed sequence ends with a normal transfer or a probe of the bank, so the recovery is visible.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_filter.sv
module i2cs_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  // level accepted only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync   <= 2'b11;
      cnt    <= '0;
      filt_o <= 1'b1;
    end else begin
      sync <= {sync[0], raw_i};
      if (sync[1] == filt_o) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        filt_o <= sync[1];
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start,
  output logic stop,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start    = scl_q & scl & sda_q & ~sda;
  assign stop     = scl_q & scl & ~sda_q & sda;
  assign scl_rise = ~scl_q & scl;
  assign scl_fall = scl_q & ~scl;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b11101,
  parameter int         PTR_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr_sel,
  input  logic             sda,
  input  logic             start,
  input  logic             stop,
  input  logic             scl_rise,
  input  logic             scl_fall,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_idx,
  output logic             reg_wr,
  output logic [7:0]       reg_wdata,
  output logic             reg_rd,
  input  logic [7:0]       reg_rdata
);
  i2cs_state_e      state;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [PTR_W-1:0] ptr;
  logic             rw_q, mack_q, wr_q;
  logic             rd_now, byte_done;

  assign byte_done = scl_fall && (bitcnt == 4'd8);
  assign rd_now    = scl_fall && ((state == ST_ADDR_ACK && rw_q) ||
                                  (state == ST_RD_ACK && mack_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      wr_q   <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (start) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_WR: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == {ADDR_HI, addr_sel}) begin
                  rw_q   <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_CMD) begin
                ptr    <= shreg[PTR_W-1:0];
                sda_oe <= 1'b1;
                state  <= ST_CMD_ACK;
              end else begin
                wr_q   <= 1'b1;
                sda_oe <= 1'b1;
                state  <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK, ST_CMD_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              if (state == ST_ADDR_ACK && rw_q) begin
                shreg  <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
                bitcnt <= '0;
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= (state == ST_ADDR_ACK) ? ST_CMD : ST_WR;
              end
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              sda_oe <= 1'b0;
              mack_q <= 1'b0;
              bitcnt <= '0;
              state  <= ST_RD_ACK;
            end else if (scl_fall) begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda;
            end else if (scl_fall) begin
              if (mack_q) begin
                shreg  <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
                bitcnt <= '0;
                state  <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
      if (wr_q || rd_now) ptr <= ptr ^ PTR_W'(1);
    end
  end

  assign reg_idx   = ptr;
  assign reg_wr    = wr_q;
  assign reg_wdata = shreg;
  assign reg_rd    = rd_now;
endmodule

// File: rtl/i2cs_cmd_slave.sv
module i2cs_cmd_slave #(
  parameter logic [4:0] ADDR_HI  = 5'b11101,
  parameter int         FILT_LEN = 4,
  parameter int         PTR_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr_sel,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_idx,
  output logic             reg_wr,
  output logic [7:0]       reg_wdata,
  output logic             reg_rd,
  input  logic [7:0]       reg_rdata
);
  localparam int NLINES = 2;  // [0] clock line, [1] data line
  logic [NLINES-1:0] raw, filt;
  logic start, stop, scl_rise, scl_fall;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2cs_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw[g]), .filt_o(filt[g])
    );
  end

  i2cs_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl(filt[0]), .sda(filt[1]),
    .start(start), .stop(stop), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2cs_engine #(.ADDR_HI(ADDR_HI), .PTR_W(PTR_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .sda(filt[1]),
    .start(start), .stop(stop), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_oe(sda_oe), .reg_idx(reg_idx), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [PTR_W-1:0] reg_idx
);
  assert_wr_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  assert_wr_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_idx == ($past(reg_idx) ^ PTR_W'(1))));

  assert_rd_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (reg_idx == ($past(reg_idx) ^ PTR_W'(1))));

  assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2cs_cmd_slave i2cs_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx)
);

// File: tb/sim_i2cs_cmd_slave.sv
module sim_i2cs_cmd_slave;
  localparam int PTR_W = 3;
  localparam int Q     = 20;

  typedef struct packed {
    logic [1:0] tgt;
    logic [1:0] pins;
    logic [7:0] cmd;
    logic [7:0] d0;
    logic [7:0] d1;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd0, 2'd0, 8'h02, 8'hA5, 8'h3C},
    '{2'd1, 2'd1, 8'h07, 8'h81, 8'h7E},
    '{2'd2, 2'd2, 8'h04, 8'hFF, 8'h00},
    '{2'd3, 2'd3, 8'h0D, 8'h12, 8'h34},
    '{2'd1, 2'd2, 8'h00, 8'h55, 8'hAA},
    '{2'd3, 2'd0, 8'h01, 8'h66, 8'h99}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr_sel = 2'd0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_bus, sda_oe, reg_wr, reg_rd, bank_clr = 1'b1;
  logic [PTR_W-1:0] reg_idx;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] bank [8];
  logic [7:0] exp_bank [8];
  int wr_cnt, rd_cnt;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2cs_cmd_slave #(.PTR_W(PTR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl_m),
    .sda_i(sda_bus), .sda_oe(sda_oe), .reg_idx(reg_idx), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = bank[reg_idx];

  always_ff @(posedge clk) begin
    if (bank_clr) begin
      for (int i = 0; i < 8; i++) bank[i] <= 8'h00;
      wr_cnt <= 0;
      rd_cnt <= 0;
    end else begin
      if (reg_wr) begin
        bank[reg_idx] <= reg_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (reg_rd) rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // mode 1: short data pulse in high phase, mode 2: short clock pulse in low phase
  task automatic bit_tx(input logic b, input int mode);
    sda_m = b;
    if (mode == 2) begin
      wq(Q / 2); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(Q / 2 - 2);
    end else wq(Q);
    scl_m = 1'b1;
    if (mode == 1) begin
      wq(Q / 2); sda_m = ~b; wq(2); sda_m = b; wq(2 * Q - Q / 2 - 2);
    end else wq(2 * Q);
    scl_m = 1'b0;
    wq(Q);
  endtask

  task automatic bit_rx(output logic b);
    sda_m = 1'b1;
    wq(Q); scl_m = 1'b1; wq(Q); b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic byte_tx(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_tx(d[i], 0);
    bit_rx(b);
    ack = ~b;
  endtask

  task automatic byte_rx(output logic [7:0] d, input logic mack);
    for (int i = 7; i >= 0; i--) bit_rx(d[i]);
    bit_tx(~mack, 0);
  endtask

  function automatic logic [7:0] abyte(input logic [1:0] t, input logic rw);
    return {5'b11101, t, rw};
  endfunction

  task automatic wr_txn(input logic [1:0] t, input logic [7:0] cmd,
                        input logic [7:0] d0, input logic [7:0] d1,
                        output logic [3:0] acks);
    do_start();
    byte_tx(abyte(t, 1'b0), acks[3]);
    byte_tx(cmd, acks[2]);
    byte_tx(d0, acks[1]);
    byte_tx(d1, acks[0]);
    do_stop();
    if (t == addr_sel) begin
      exp_bank[cmd[2:0]] = d0;
      exp_bank[cmd[2:0] ^ 3'd1] = d1;
    end
  endtask

  task automatic rd_setup(input logic [1:0] t, input logic [7:0] cmd, output logic [2:0] acks);
    do_start();
    byte_tx(abyte(t, 1'b0), acks[2]);
    byte_tx(cmd, acks[1]);
    do_start();
    byte_tx(abyte(t, 1'b1), acks[0]);
  endtask

  logic wd_hit = 1'b0;
  initial begin
    repeat (180000) @(posedge clk);
    wd_hit = 1'b1;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] a4;
    logic [2:0] a3;
    logic [7:0] r0, r1, r2;
    logic a;
    int w0, c0;
    for (int i = 0; i < 8; i++) exp_bank[i] = 8'h00;

    // reset state (R9)
    wq(5);
    chk("R9 reset sda_oe", sda_oe, 0);
    chk("R9 reset strobes", {reg_wr, reg_rd}, 0);
    rst_n = 1'b1;
    bank_clr = 1'b0;
    wq(10);

    // vector walk: write a pair, read it back (R1..R6)
    for (int v = 0; v < 6; v++) begin
      addr_sel = VEC[v].pins;
      wq(4);
      w0 = wr_cnt; c0 = rd_cnt;
      wr_txn(VEC[v].tgt, VEC[v].cmd, VEC[v].d0, VEC[v].d1, a4);
      if (VEC[v].tgt == VEC[v].pins) begin
        chk("R1 R2 R3 write acks", a4, 4'hF);
        chk("R3 first data byte", bank[VEC[v].cmd[2:0]], VEC[v].d0);
        chk("R4 paired data byte", bank[VEC[v].cmd[2:0] ^ 3'd1], VEC[v].d1);
        rd_setup(VEC[v].tgt, VEC[v].cmd, a3);
        byte_rx(r0, 1'b1);
        byte_rx(r1, 1'b0);
        do_stop();
        chk("R1 R5 read acks", a3, 3'h7);
        chk("R5 read first", r0, VEC[v].d0);
        chk("R4 R6 read second", r1, VEC[v].d1);
      end else begin
        chk("R1 foreign addr no ack", a4[3], 0);
        chk("R1 foreign addr no write", wr_cnt - w0, 0);
        rd_setup(VEC[v].tgt, VEC[v].cmd, a3);
        byte_rx(r0, 1'b0);
        do_stop();
        chk("R1 foreign read no ack", a3, 0);
        chk("R1 foreign read no strobe", rd_cnt - c0, 0);
      end
    end

    addr_sel = 2'd0;
    wq(4);

    // STOP inside a byte (R7)
    do_start();
    for (int i = 0; i < 4; i++) bit_tx(1'b1, 0);
    do_stop();
    wr_txn(2'd0, 8'h01, 8'h99, 8'h98, a4);
    chk("R7 after stop acks", a4, 4'hF);
    chk("R7 after stop data", bank[1], 8'h99);

    // START inside a byte (R7)
    do_start();
    for (int i = 0; i < 3; i++) bit_tx(1'b1, 0);
    wr_txn(2'd0, 8'h03, 8'h42, 8'h24, a4);
    chk("R7 after restart acks", a4, 4'hF);
    chk("R7 after restart data", bank[3], 8'h42);

    // short pulses on both lines (R8): byte 6B, sda pulse in bit 6, scl pulse in bit 4
    do_start();
    byte_tx(abyte(2'd0, 1'b0), a);
    byte_tx(8'h05, a);
    for (int i = 7; i >= 0; i--) bit_tx(8'h6B >> i, (i == 6) ? 1 : ((i == 4) ? 2 : 0));
    bit_rx(r0[0]);
    do_stop();
    exp_bank[5] = 8'h6B;
    chk("R8 glitch ack", r0[0], 1'b0);
    chk("R8 glitch data", bank[5], exp_bank[5]);

    // three reads in a row wrap inside the pair (R4)
    rd_setup(2'd0, 8'h04, a3);
    byte_rx(r0, 1'b1);
    byte_rx(r1, 1'b1);
    byte_rx(r2, 1'b0);
    do_stop();
    chk("R4 wrap read 0", r0, exp_bank[4]);
    chk("R4 wrap read 1", r1, exp_bank[5]);
    chk("R4 wrap read 2", r2, exp_bank[4]);

    // master NACK ends the read (R6)
    c0 = rd_cnt;
    rd_setup(2'd0, 8'h00, a3);
    byte_rx(r0, 1'b0);
    byte_rx(r1, 1'b0);
    do_stop();
    chk("R6 byte before nack", r0, exp_bank[0]);
    chk("R6 released after nack", r1, 8'hFF);
    chk("R6 single strobe", rd_cnt - c0, 1);

    // reset mid transaction (R9)
    do_start();
    byte_tx(abyte(2'd0, 1'b0), a);
    byte_tx(8'h02, a);
    w0 = wr_cnt;
    rst_n = 1'b0;
    wq(3);
    chk("R9 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    wq(3);
    byte_tx(8'h77, a);
    do_stop();
    chk("R9 byte after reset no ack", a, 0);
    chk("R9 byte after reset no write", wr_cnt - w0, 0);
    chk("R9 bank unchanged", bank[2], exp_bank[2]);

    if (!wd_hit) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule